// File: doc/BRIEF.md
# Feedback-Directed Prefetch Throttle

This block watches how useful a hardware prefetcher has been and adjusts how hard it pushes. Five single-cycle event pulses feed it: a prefetch was issued, a prefetched block was used by a demand access, a demand arrived while its prefetch was still in flight (late), a demand miss hit a block that a prefetch had evicted (pollution), and any demand miss. A sixth pulse marks each cache block eviction. Eviction pulses are counted against a programmable length, and each group of that many evictions forms one interval.

When an interval closes, the block sorts accuracy (used over issued) into three classes using integer cross-multiplication. It also raises a lateness flag and a pollution flag. A fixed decision table then moves a five-step aggressiveness level up one step, down one step, or leaves it where it is. The level drives a prefetch distance and a prefetch degree for the prefetcher. The pollution flag also picks whether newly prefetched blocks should enter the cache at the LRU or the MRU end. At interval close every event counter is halved, not cleared, so older intervals still weigh on later decisions.

Top module: `pf_throttle`

## Requirements
- R1: After reset the level is 2, distance 16, degree 2, `insert_lru` is 0 (MRU placement) and `adjust_done` is 0.
- R2: Distance equals 4 shifted left by the level (4, 8, 16, 32, 64 for levels 0 to 4). Degree is 1, 1, 2, 3, 4 for levels 0 to 4.
- R3: An interval closes on the clock edge that takes the eviction pulse completing `interval_len` evictions since the last close. `adjust_done` is 1 for exactly the following cycle. The level and `insert_lru` change only at that edge, and the eviction count then restarts from zero.
- R4: Accuracy is high when used*4 >= issued*3. It is low when used*5 < issued*2. Otherwise it is medium. With no prefetches issued, accuracy counts as high.
- R5: The lateness flag is set when late*64 > used. The pollution flag is set when polluting*200 > demand misses.
- R6: With high accuracy, lateness steps the level up. Without lateness but with pollution, the level steps down. With neither flag, the level holds.
- R7: With medium accuracy, pollution steps the level down. Without pollution, lateness steps it up. With neither flag, the level holds.
- R8: With low accuracy, the level holds only when neither flag is set. In every other low-accuracy case it steps down.
- R9: The level saturates at 0 and at 4 and moves by at most one step per interval.
- R10: At each interval close `insert_lru` takes the value of the pollution flag.
- R11: At interval close every event counter becomes half of its value including that cycle's event (rounded down). Counters saturate at their maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_len | input | 16 | Evictions per interval (0 behaves as 1) |
| ev_sent | input | 1 | A prefetch was issued |
| ev_used | input | 1 | A demand used a prefetched block |
| ev_late | input | 1 | A demand found its prefetch still in flight |
| ev_pollute | input | 1 | A demand missed on a block a prefetch evicted |
| ev_miss | input | 1 | A demand miss occurred |
| ev_evict | input | 1 | A cache block was evicted |
| level | output | 3 | Current aggressiveness level, 0 to 4 |
| pf_distance | output | 7 | Prefetch distance in blocks |
| pf_degree | output | 3 | Prefetches per demand access |
| insert_lru | output | 1 | 1: insert prefetched blocks at LRU, 0: at MRU |
| adjust_done | output | 1 | Pulses the cycle after an interval closes |

## Verification
A corrupted counter or classifier in this block does not show up at the ports until the next interval closes. It then appears as a wrong level, distance, degree or insertion hint in the cycle where `adjust_done` pulses. Because counters are halved rather than cleared, a counting error can affect decisions for several intervals. The bench therefore checks the outputs on each closing cycle. It covers every cell of the decision table, each threshold on both sides, saturation at both ends, and two-interval sequences whose outcome depends on the history that is carried over.

// File: rtl/pf_thr_pkg.sv
package pf_thr_pkg;
   typedef enum logic [1:0] {ACC_LOW, ACC_MED, ACC_HIGH} acc_e;
   typedef enum logic [1:0] {ACT_HOLD, ACT_UP, ACT_DOWN} act_e;
   localparam int NUM_EV  = 5;
   localparam int EV_SENT = 0;
   localparam int EV_USED = 1;
   localparam int EV_LATE = 2;
   localparam int EV_POLL = 3;
   localparam int EV_MISS = 4;
endpackage

// File: rtl/pf_thr_counter.sv
module pf_thr_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          halve,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] nxt;

   always_comb begin
      if (inc && cnt != {CW{1'b1}}) nxt = cnt + CW'(1);
      else                          nxt = cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (halve) cnt <= nxt >> 1;
      else            cnt <= nxt;
   end
endmodule

// File: rtl/pf_thr_interval.sv
module pf_thr_interval #(
   parameter int EW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_evict,
   input  logic [EW-1:0] interval_len,
   output logic          close_o
);
   logic [EW-1:0] seen;
   logic [EW:0]   seen_inc;

   assign seen_inc = {1'b0, seen} + (EW+1)'(1);
   assign close_o  = ev_evict && (seen_inc >= {1'b0, interval_len});

   always_ff @(posedge clk) begin
      if (!rst_n)        seen <= '0;
      else if (close_o)  seen <= '0;
      else if (ev_evict) seen <= seen_inc[EW-1:0];
   end
endmodule

// File: rtl/pf_thr_classify.sv
module pf_thr_classify
   import pf_thr_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic [CW-1:0] sent,
   input  logic [CW-1:0] used,
   input  logic [CW-1:0] late,
   input  logic [CW-1:0] poll,
   input  logic [CW-1:0] miss,
   output acc_e          acc,
   output logic          late_f,
   output logic          poll_f,
   output act_e          act
);
   localparam int XW = CW + 8;
   logic [XW-1:0] s, u, l, p, m;

   assign s = XW'(sent);
   assign u = XW'(used);
   assign l = XW'(late);
   assign p = XW'(poll);
   assign m = XW'(miss);

   always_comb begin
      if (u * XW'(4) >= s * XW'(3))     acc = ACC_HIGH;
      else if (u * XW'(5) < s * XW'(2)) acc = ACC_LOW;
      else                              acc = ACC_MED;
      late_f = (l * XW'(64)) > u;
      poll_f = (p * XW'(200)) > m;
   end

   always_comb begin
      act = ACT_HOLD;
      unique case (acc)
         ACC_HIGH: begin
            if (late_f)      act = ACT_UP;
            else if (poll_f) act = ACT_DOWN;
         end
         ACC_MED: begin
            if (poll_f)      act = ACT_DOWN;
            else if (late_f) act = ACT_UP;
         end
         default: begin
            if (poll_f || late_f) act = ACT_DOWN;
         end
      endcase
   end
endmodule

// File: rtl/pf_thr_level.sv
module pf_thr_level
   import pf_thr_pkg::*;
#(
   parameter int NUM_LEVELS  = 5,
   parameter int RESET_LEVEL = 2,
   parameter int MIN_DIST    = 4,
   parameter int LW          = 3,
   parameter int DW          = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          apply,
   input  act_e          act,
   input  logic          poll_f,
   output logic [LW-1:0] level,
   output logic [DW-1:0] distance,
   output logic [LW-1:0] degree,
   output logic          insert_lru,
   output logic          done
);
   localparam logic [LW-1:0] TOP = LW'(NUM_LEVELS - 1);
   logic [LW-1:0] nxt;

   always_comb begin
      nxt = level;
      if (act == ACT_UP && level != TOP)        nxt = level + LW'(1);
      else if (act == ACT_DOWN && level != '0)  nxt = level - LW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level      <= LW'(RESET_LEVEL);
         insert_lru <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= apply;
         if (apply) begin
            level      <= nxt;
            insert_lru <= poll_f;
         end
      end
   end

   assign distance = DW'(MIN_DIST) << level;
   assign degree   = (level == '0) ? LW'(1) : level;
endmodule

// File: rtl/pf_throttle.sv
module pf_throttle
   import pf_thr_pkg::*;
#(
   parameter int CW          = 16,
   parameter int EW          = 16,
   parameter int NUM_LEVELS  = 5,
   parameter int RESET_LEVEL = 2,
   parameter int MIN_DIST    = 4,
   parameter int LW          = $clog2(NUM_LEVELS),
   parameter int DW          = $clog2(MIN_DIST << (NUM_LEVELS - 1)) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [EW-1:0] interval_len,
   input  logic          ev_sent,
   input  logic          ev_used,
   input  logic          ev_late,
   input  logic          ev_pollute,
   input  logic          ev_miss,
   input  logic          ev_evict,
   output logic [LW-1:0] level,
   output logic [DW-1:0] pf_distance,
   output logic [LW-1:0] pf_degree,
   output logic          insert_lru,
   output logic          adjust_done
);
   generate
      if (NUM_LEVELS < 2) begin : g_bad_levels
         $error("pf_throttle: NUM_LEVELS must be at least 2");
      end
      if (RESET_LEVEL >= NUM_LEVELS) begin : g_bad_reset
         $error("pf_throttle: RESET_LEVEL out of range");
      end
      if (MIN_DIST < 1 || (MIN_DIST & (MIN_DIST - 1)) != 0) begin : g_bad_dist
         $error("pf_throttle: MIN_DIST must be a power of two");
      end
      if (CW < 4 || EW < 1) begin : g_bad_width
         $error("pf_throttle: counter widths too small");
      end
   endgenerate

   logic [NUM_EV-1:0] ev_vec;
   logic [CW-1:0]     cnt [NUM_EV];
   logic              closing;
   acc_e              acc;
   act_e              act;
   logic              late_f, poll_f;

   assign ev_vec[EV_SENT] = ev_sent;
   assign ev_vec[EV_USED] = ev_used;
   assign ev_vec[EV_LATE] = ev_late;
   assign ev_vec[EV_POLL] = ev_pollute;
   assign ev_vec[EV_MISS] = ev_miss;

   pf_thr_interval #(.EW(EW)) u_interval (
      .clk(clk), .rst_n(rst_n), .ev_evict(ev_evict),
      .interval_len(interval_len), .close_o(closing)
   );

   generate
      for (genvar g = 0; g < NUM_EV; g++) begin : g_ctr
         pf_thr_counter #(.CW(CW)) u_ctr (
            .clk(clk), .rst_n(rst_n), .inc(ev_vec[g]),
            .halve(closing), .cnt(cnt[g])
         );
      end
   endgenerate

   pf_thr_classify #(.CW(CW)) u_class (
      .sent(cnt[EV_SENT]), .used(cnt[EV_USED]), .late(cnt[EV_LATE]),
      .poll(cnt[EV_POLL]), .miss(cnt[EV_MISS]),
      .acc(acc), .late_f(late_f), .poll_f(poll_f), .act(act)
   );

   pf_thr_level #(
      .NUM_LEVELS(NUM_LEVELS), .RESET_LEVEL(RESET_LEVEL),
      .MIN_DIST(MIN_DIST), .LW(LW), .DW(DW)
   ) u_level (
      .clk(clk), .rst_n(rst_n), .apply(closing), .act(act), .poll_f(poll_f),
      .level(level), .distance(pf_distance), .degree(pf_degree),
      .insert_lru(insert_lru), .done(adjust_done)
   );
endmodule

// File: rtl/pf_throttle_chk.sv
module pf_throttle_chk #(
   parameter int NUM_LEVELS = 5,
   parameter int LW         = 3,
   parameter int DW         = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ev_evict,
   input logic [LW-1:0] level,
   input logic [DW-1:0] pf_distance,
   input logic [LW-1:0] pf_degree,
   input logic          insert_lru,
   input logic          adjust_done
);
   // R3
   level_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level != $past(level)) |-> adjust_done);

   // R3
   done_follows_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adjust_done |-> $past(ev_evict));

   // R9
   level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level) < NUM_LEVELS);

   // R9
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adjust_done |-> (int'(level) == int'($past(level)) ||
                       int'(level) == int'($past(level)) + 1 ||
                       int'(level) + 1 == int'($past(level))));

   // R10
   insert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adjust_done |-> $stable(insert_lru));

   // R2
   distance_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pf_distance) == 1);

   // R2
   degree_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_degree != '0 && int'(pf_degree) <= int'(level) + 1);
endmodule

bind pf_throttle pf_throttle_chk #(
   .NUM_LEVELS(NUM_LEVELS), .LW(LW), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_evict(ev_evict), .level(level),
   .pf_distance(pf_distance), .pf_degree(pf_degree),
   .insert_lru(insert_lru), .adjust_done(adjust_done)
);

// File: tb/tb_pf_throttle.sv
`timescale 1ns/1ps
module tb_pf_throttle;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] interval_len = 16'd4;
   logic        ev_sent = 0, ev_used = 0, ev_late = 0, ev_pollute = 0, ev_miss = 0, ev_evict = 0;
   logic [2:0]  level;
   logic [6:0]  pf_distance;
   logic [2:0]  pf_degree;
   logic        insert_lru;
   logic        adjust_done;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pf_throttle dut (
      .clk(clk), .rst_n(rst_n), .interval_len(interval_len),
      .ev_sent(ev_sent), .ev_used(ev_used), .ev_late(ev_late),
      .ev_pollute(ev_pollute), .ev_miss(ev_miss), .ev_evict(ev_evict),
      .level(level), .pf_distance(pf_distance), .pf_degree(pf_degree),
      .insert_lru(insert_lru), .adjust_done(adjust_done)
   );

   // columns: sent, used, late, pollute, miss, level delta, expected insert_lru
   localparam int NV = 18;
   localparam int VT [NV][7] = '{
      '{100, 80, 0, 0, 100,  0, 0},
      '{100, 80, 5, 0, 100,  1, 0},
      '{100, 80, 1, 1, 100, -1, 1},
      '{100, 80, 5, 1, 100,  1, 1},
      '{100, 50, 2, 0, 100,  1, 0},
      '{100, 50, 0, 0, 100,  0, 0},
      '{100, 50, 0, 1, 100, -1, 1},
      '{100, 30, 0, 0, 100,  0, 0},
      '{100, 30, 1, 0, 100, -1, 0},
      '{100, 30, 0, 1, 100, -1, 1},
      '{100, 75, 2, 1, 100,  1, 1},
      '{100, 74, 2, 1, 100, -1, 1},
      '{100, 40, 1, 0, 100,  1, 0},
      '{100, 39, 1, 0, 100, -1, 0},
      '{ 80, 64, 1, 0, 100,  0, 0},
      '{ 80, 63, 1, 0, 100,  1, 0},
      '{100, 80, 0, 1, 200,  0, 0},
      '{100, 80, 0, 1, 199, -1, 1}
   };

   function automatic string vec_tag(int i);
      if (i < 4)  return "R6";
      if (i < 7)  return "R7";
      if (i < 10) return "R8";
      if (i < 14) return "R4";
      return "R5";
   endfunction

   function automatic int exp_dist(int lv);
      return 4 << lv;
   endfunction

   function automatic int exp_deg(int lv);
      return (lv == 0) ? 1 : lv;
   endfunction

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drive_events(int ns, int nu, int nl, int np, int nm);
      int mx = ns;
      if (nu > mx) mx = nu;
      if (nl > mx) mx = nl;
      if (np > mx) mx = np;
      if (nm > mx) mx = nm;
      for (int i = 0; i < mx; i++) begin
         @(negedge clk);
         ev_sent = (i < ns); ev_used = (i < nu); ev_late = (i < nl);
         ev_pollute = (i < np); ev_miss = (i < nm);
      end
      @(negedge clk);
      ev_sent = 0; ev_used = 0; ev_late = 0; ev_pollute = 0; ev_miss = 0;
   endtask

   // returns at the negedge right after the closing edge
   task automatic close_interval();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         ev_evict = 1'b1;
      end
      @(negedge clk);
      ev_evict = 1'b0;
   endtask

   task automatic run_interval(int ns, int nu, int nl, int np, int nm);
      drive_events(ns, nu, nl, np, nm);
      close_interval();
   endtask

   initial begin
      #600000;
      tests++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 level", int'(level), 2);
      chk("R1 distance", int'(pf_distance), 16);
      chk("R1 degree", int'(pf_degree), 2);
      chk("R1 insert_lru", int'(insert_lru), 0);
      chk("R1 adjust_done", int'(adjust_done), 0);

      // decision table walk, fresh history per vector
      for (int v = 0; v < NV; v++) begin
         do_reset();
         run_interval(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4]);
         chk({vec_tag(v), " level"}, int'(level), 2 + VT[v][5]);
         chk({vec_tag(v), " insert_lru R10"}, int'(insert_lru), VT[v][6]);
         chk({vec_tag(v), " done R3"}, int'(adjust_done), 1);
      end

      // R3 interval length and done pulse width
      do_reset();
      drive_events(100, 80, 5, 0, 100);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         ev_evict = 1'b1;
      end
      @(negedge clk);
      ev_evict = 1'b0;
      chk("R3 no close after 3 evictions (done)", int'(adjust_done), 0);
      chk("R3 no close after 3 evictions (level)", int'(level), 2);
      @(negedge clk);
      ev_evict = 1'b1;
      @(negedge clk);
      ev_evict = 1'b0;
      chk("R3 close on 4th eviction (done)", int'(adjust_done), 1);
      chk("R3 close on 4th eviction (level)", int'(level), 3);
      @(negedge clk);
      chk("R3 done lasts one cycle", int'(adjust_done), 0);
      chk("R3 level stable after close", int'(level), 3);

      // R9 saturation upward, R2 tables
      do_reset();
      run_interval(100, 80, 5, 0, 100);
      chk("R9 up step 1", int'(level), 3);
      chk("R2 distance lvl3", int'(pf_distance), exp_dist(3));
      chk("R2 degree lvl3", int'(pf_degree), exp_deg(3));
      run_interval(100, 80, 5, 0, 100);
      chk("R9 up step 2", int'(level), 4);
      run_interval(100, 80, 5, 0, 100);
      chk("R9 saturate at top", int'(level), 4);
      chk("R2 distance lvl4", int'(pf_distance), exp_dist(4));
      chk("R2 degree lvl4", int'(pf_degree), exp_deg(4));

      // R9 saturation downward
      do_reset();
      run_interval(100, 30, 1, 0, 100);
      chk("R9 down step 1", int'(level), 1);
      chk("R2 distance lvl1", int'(pf_distance), exp_dist(1));
      chk("R2 degree lvl1", int'(pf_degree), exp_deg(1));
      run_interval(100, 30, 1, 0, 100);
      chk("R9 down step 2", int'(level), 0);
      run_interval(100, 30, 1, 0, 100);
      chk("R9 saturate at bottom", int'(level), 0);
      chk("R2 distance lvl0", int'(pf_distance), exp_dist(0));
      chk("R2 degree lvl0", int'(pf_degree), exp_deg(0));

      // R10 insert hint returns to MRU when pollution clears
      do_reset();
      run_interval(100, 80, 1, 1, 100);
      chk("R10 set on pollution", int'(insert_lru), 1);
      run_interval(0, 0, 0, 0, 300);
      chk("R10 cleared without pollution", int'(insert_lru), 0);
      chk("R6 hold on second interval", int'(level), 1);

      // R11 halved history steers the next decision
      do_reset();
      run_interval(100, 20, 0, 0, 100);
      chk("R8 low hold before history test", int'(level), 2);
      run_interval(10, 10, 1, 0, 0);
      chk("R11 history keeps accuracy low", int'(level), 1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule